// File: doc/BRIEF.md
# Register Window Spill/Fill Controller

This block keeps the windowed-register bookkeeping for a core with a configurable number of register windows. It owns the current window pointer and five pieces of context: the count of windows that can still be saved into, the count that can be restored from, the count of clean windows, the count of windows held by another context, and a 6-bit window-state word that supplies trap vector selectors. The pipeline presents one window request per cycle: save, restore or return.

For every request the block does one of two things. It either commits the window move and adjusts the counters in lockstep, or it raises exactly one trap with an encoded trap kind and a 3-bit vector selector and leaves all state untouched. Each response also carries the sum of the two operands. For save and restore this sum is the result written into the new window. For return it is the branch target. A successful return also asserts a redirect flag. A separate load port lets privileged logic overwrite the whole context at once, for example on a context switch.

All responses are registered. A request seen at a clock edge produces its response on the outputs after that edge, and the updated context is visible at the same time.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the savable and clean counts are NWIN-2, the restorable and other-context counts are 0, the window-state word is 0, and no response is valid.
- R2: A save with savable count 0 raises a spill trap. The kind is 2 (spill-other) with vector = window-state bits 5:3 when the other-context count is nonzero. Otherwise the kind is 1 (spill-normal) with vector = bits 2:0.
- R3: A save with a nonzero savable count raises trap kind 5 (clean-window) with vector 0 when the clean count equals the restorable count.
- R4: A committed save sets the pointer to (pointer+1) mod NWIN, decrements the savable count and increments the restorable count.
- R5: A restore or return with restorable count 0 raises a fill trap. The kind is 4 (fill-other) with vector = bits 5:3 when the other-context count is nonzero. Otherwise the kind is 3 (fill-normal) with vector = bits 2:0.
- R6: A committed restore sets the pointer to (pointer-1+NWIN) mod NWIN, increments the savable count and decrements the restorable count.
- R7: A return whose fill condition does not hold raises trap kind 6 (misaligned) with vector 0 when bit 1 or bit 0 of opa+opb is set. The fill check takes priority over this check.
- R8: A committed return updates state as R6 and asserts the redirect output. Redirect is low on every other response.
- R9: Every response carries opa+opb (modulo 2^DATA_W) on the value output.
- R10: Each response has exactly one of commit and trap set. A trap leaves the pointer and all counters unchanged. Commit responses report kind 0.
- R11: A load writes every context field from the load inputs at the next edge. A request presented in the same cycle is dropped: it gives no response and has no effect.
- R12: Request code 0 means idle and produces no response. Codes are 1 save, 2 restore, 3 return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 2 | Request: 0 idle, 1 save, 2 restore, 3 return |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand |
| ld_en | input | 1 | Load whole context |
| ld_cwp | input | 5 | Pointer value to load |
| ld_cansave | input | 5 | Savable count to load |
| ld_canrestore | input | 5 | Restorable count to load |
| ld_cleanwin | input | 5 | Clean count to load |
| ld_otherwin | input | 5 | Other-context count to load |
| ld_wstate | input | 6 | Window-state word to load |
| rsp_valid | output | 1 | Response present |
| rsp_commit | output | 1 | Request committed |
| rsp_trap | output | 1 | Request trapped |
| rsp_kind | output | 3 | Trap kind code |
| rsp_vec | output | 3 | Trap vector selector |
| rsp_redirect | output | 1 | Return redirects to rsp_value |
| rsp_value | output | DATA_W | opa+opb for this request |
| cwp | output | 5 | Current window pointer |
| cansave | output | 5 | Savable window count |
| canrestore | output | 5 | Restorable window count |
| cleanwin | output | 5 | Clean window count |
| otherwin | output | 5 | Other-context window count |
| wstate | output | 6 | Window-state word |

## Verification
The bench targets both ends of the pointer range. It saves from pointer NWIN-1 and restores from pointer 0. A design with a wrong modulo would step to NWIN or to 31 instead of wrapping. It builds a return that is both misaligned and fill-blocked, where a wrong priority order would report kind 6 instead of a fill trap. It flips the other-context count between zero and nonzero with distinct window-state halves, so a swapped field select shows up as a wrong vector. It issues a load together with a request, where a design that lets the request through would emit an unexpected response or move the counters. It sets the clean count equal to the restorable count, where a missed clean-window check would let the save commit.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int PTR_W = 5;
    localparam int CNT_W = 5;
    localparam int WST_W = 6;
    localparam int VEC_W = 3;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_SAVE    = 2'd1,
        OP_RESTORE = 2'd2,
        OP_RETURN  = 2'd3
    } rwin_op_e;

    typedef enum logic [2:0] {
        TK_NONE     = 3'd0,
        TK_SPILL_N  = 3'd1,
        TK_SPILL_O  = 3'd2,
        TK_FILL_N   = 3'd3,
        TK_FILL_O   = 3'd4,
        TK_CLEAN    = 3'd5,
        TK_MISALIGN = 3'd6
    } rwin_trap_e;

    typedef struct packed {
        logic [PTR_W-1:0] cwp;
        logic [CNT_W-1:0] cansave;
        logic [CNT_W-1:0] canrestore;
        logic [CNT_W-1:0] cleanwin;
        logic [CNT_W-1:0] otherwin;
        logic [WST_W-1:0] wstate;
    } rwin_ctx_t;

endpackage

// File: rtl/rwin_ptr_step.sv
module rwin_ptr_step
    import rwin_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic [PTR_W-1:0] cur,
    output logic [PTR_W-1:0] nxt_up,
    output logic [PTR_W-1:0] nxt_dn
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NWIN - 1);

    always_comb begin
        if (cur >= LAST) nxt_up = '0;
        else             nxt_up = cur + PTR_W'(1);
        if (cur == '0 || cur > LAST) nxt_dn = LAST;
        else                         nxt_dn = cur - PTR_W'(1);
    end
endmodule

// File: rtl/rwin_sum.sv
module rwin_sum #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    always_comb s = a + b;
endmodule

// File: rtl/rwin_trap_eval.sv
module rwin_trap_eval
    import rwin_pkg::*;
(
    input  rwin_op_e        op,
    input  rwin_ctx_t       ctx,
    input  logic [1:0]      tgt_low,
    output rwin_trap_e      kind,
    output logic [VEC_W-1:0] vec,
    output logic            commit
);
    logic             no_save;
    logic             no_rest;
    logic             other;
    logic             clean_hit;
    logic [VEC_W-1:0] fld;

    always_comb begin
        no_save   = (ctx.cansave == '0);
        no_rest   = (ctx.canrestore == '0);
        other     = (ctx.otherwin != '0);
        clean_hit = ((ctx.cleanwin - ctx.canrestore) == '0);
        fld       = other ? ctx.wstate[5:3] : ctx.wstate[2:0];

        kind   = TK_NONE;
        vec    = '0;
        commit = 1'b0;
        unique case (op)
            OP_SAVE: begin
                if (no_save) begin
                    kind = other ? TK_SPILL_O : TK_SPILL_N;
                    vec  = fld;
                end else if (clean_hit) begin
                    kind = TK_CLEAN;
                end else begin
                    commit = 1'b1;
                end
            end
            OP_RESTORE: begin
                if (no_rest) begin
                    kind = other ? TK_FILL_O : TK_FILL_N;
                    vec  = fld;
                end else begin
                    commit = 1'b1;
                end
            end
            OP_RETURN: begin
                if (no_rest) begin
                    kind = other ? TK_FILL_O : TK_FILL_N;
                    vec  = fld;
                end else if (tgt_low != 2'b00) begin
                    kind = TK_MISALIGN;
                end else begin
                    commit = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              ld_en,
    input  logic [4:0]        ld_cwp,
    input  logic [4:0]        ld_cansave,
    input  logic [4:0]        ld_canrestore,
    input  logic [4:0]        ld_cleanwin,
    input  logic [4:0]        ld_otherwin,
    input  logic [5:0]        ld_wstate,
    output logic              rsp_valid,
    output logic              rsp_commit,
    output logic              rsp_trap,
    output logic [2:0]        rsp_kind,
    output logic [2:0]        rsp_vec,
    output logic              rsp_redirect,
    output logic [DATA_W-1:0] rsp_value,
    output logic [4:0]        cwp,
    output logic [4:0]        cansave,
    output logic [4:0]        canrestore,
    output logic [4:0]        cleanwin,
    output logic [4:0]        otherwin,
    output logic [5:0]        wstate
);
    localparam logic [CNT_W-1:0] RST_AVAIL = CNT_W'(NWIN - 2);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    typedef struct packed {
        rwin_ctx_t         ctx;
        logic              valid;
        logic              commit;
        logic              trap;
        logic              redirect;
        rwin_trap_e        kind;
        logic [VEC_W-1:0]  vec;
        logic [DATA_W-1:0] value;
    } state_t;

    state_t st_d, st_q;

    rwin_op_e          op;
    logic [DATA_W-1:0] sum;
    logic [PTR_W-1:0]  ptr_up, ptr_dn;
    rwin_trap_e        ev_kind;
    logic [VEC_W-1:0]  ev_vec;
    logic              ev_commit;

    assign op = rwin_op_e'(req_op);

    rwin_sum #(.W(DATA_W)) u_sum (
        .a (opa),
        .b (opb),
        .s (sum)
    );

    rwin_ptr_step #(.NWIN(NWIN)) u_step (
        .cur    (st_q.ctx.cwp),
        .nxt_up (ptr_up),
        .nxt_dn (ptr_dn)
    );

    rwin_trap_eval u_eval (
        .op      (op),
        .ctx     (st_q.ctx),
        .tgt_low (sum[1:0]),
        .kind    (ev_kind),
        .vec     (ev_vec),
        .commit  (ev_commit)
    );

    always_comb begin
        st_d          = st_q;
        st_d.valid    = 1'b0;
        st_d.commit   = 1'b0;
        st_d.trap     = 1'b0;
        st_d.redirect = 1'b0;
        st_d.kind     = TK_NONE;
        st_d.vec      = '0;
        if (ld_en) begin
            st_d.ctx.cwp        = ld_cwp;
            st_d.ctx.cansave    = ld_cansave;
            st_d.ctx.canrestore = ld_canrestore;
            st_d.ctx.cleanwin   = ld_cleanwin;
            st_d.ctx.otherwin   = ld_otherwin;
            st_d.ctx.wstate     = ld_wstate;
        end else if (op != OP_IDLE) begin
            st_d.valid    = 1'b1;
            st_d.value    = sum;
            st_d.commit   = ev_commit;
            st_d.trap     = !ev_commit;
            st_d.kind     = ev_kind;
            st_d.vec      = ev_vec;
            st_d.redirect = ev_commit && (op == OP_RETURN);
            if (ev_commit) begin
                if (op == OP_SAVE) begin
                    st_d.ctx.cwp        = ptr_up;
                    st_d.ctx.cansave    = st_q.ctx.cansave - ONE;
                    st_d.ctx.canrestore = st_q.ctx.canrestore + ONE;
                end else begin
                    st_d.ctx.cwp        = ptr_dn;
                    st_d.ctx.cansave    = st_q.ctx.cansave + ONE;
                    st_d.ctx.canrestore = st_q.ctx.canrestore - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q                <= '0;
            st_q.ctx.cansave    <= RST_AVAIL;
            st_q.ctx.cleanwin   <= RST_AVAIL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.valid;
    assign rsp_commit   = st_q.commit;
    assign rsp_trap     = st_q.trap;
    assign rsp_kind     = st_q.kind;
    assign rsp_vec      = st_q.vec;
    assign rsp_redirect = st_q.redirect;
    assign rsp_value    = st_q.value;
    assign cwp          = st_q.ctx.cwp;
    assign cansave      = st_q.ctx.cansave;
    assign canrestore   = st_q.ctx.canrestore;
    assign cleanwin     = st_q.ctx.cleanwin;
    assign otherwin     = st_q.ctx.otherwin;
    assign wstate       = st_q.ctx.wstate;
endmodule

// File: rtl/rwin_chk.sv
module rwin_chk #(
    parameter int NWIN = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req_op,
    input logic       ld_en,
    input logic       rsp_valid,
    input logic       rsp_commit,
    input logic       rsp_trap,
    input logic [2:0] rsp_kind,
    input logic [4:0] cwp,
    input logic [4:0] cansave,
    input logic [4:0] canrestore
);
    localparam logic [4:0] LAST = 5'(NWIN - 1);

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_commit ^ rsp_trap));

    p_trap_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap) |-> (cwp == $past(cwp) && cansave == $past(cansave)
                                     && canrestore == $past(canrestore)));

    p_save_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_commit && $past(req_op) == 2'd1) |->
            (cwp == (($past(cwp) == LAST) ? 5'd0 : $past(cwp) + 5'd1)));

    p_back_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_commit && $past(req_op) != 2'd1) |->
            (cwp == (($past(cwp) == 5'd0) ? LAST : $past(cwp) - 5'd1)));

    p_spill_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap && (rsp_kind == 3'd1 || rsp_kind == 3'd2)) |-> ($past(cansave) == 5'd0));

    p_fill_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap && (rsp_kind == 3'd3 || rsp_kind == 3'd4)) |-> ($past(canrestore) == 5'd0));

    p_load_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ld_en) |-> !rsp_valid);
endmodule

bind rwin_ctrl rwin_chk #(.NWIN(NWIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_op     (req_op),
    .ld_en      (ld_en),
    .rsp_valid  (rsp_valid),
    .rsp_commit (rsp_commit),
    .rsp_trap   (rsp_trap),
    .rsp_kind   (rsp_kind),
    .cwp        (cwp),
    .cansave    (cansave),
    .canrestore (canrestore)
);

// File: tb/sim_rwin_ctrl.sv
module sim_rwin_ctrl;
    localparam int N = 8;
    localparam int W = 64;

    typedef struct packed {
        logic         commit;
        logic         trap;
        logic [2:0]   kind;
        logic [2:0]   vec;
        logic         redirect;
        logic [4:0]   cwp;
        logic [4:0]   cs;
        logic [4:0]   cr;
        logic [W-1:0] value;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   req_op = 2'd0;
    logic [W-1:0] opa = '0, opb = '0;
    logic         ld_en = 1'b0;
    logic [4:0]   ld_cwp = '0, ld_cs = '0, ld_cr = '0, ld_cl = '0, ld_ow = '0;
    logic [5:0]   ld_ws = '0;
    logic         rsp_valid, rsp_commit, rsp_trap, rsp_redirect;
    logic [2:0]   rsp_kind, rsp_vec;
    logic [W-1:0] rsp_value;
    logic [4:0]   cwp, cansave, canrestore, cleanwin, otherwin;
    logic [5:0]   wstate;

    int compared = 0;
    int mismatched = 0;
    item_t exp_q[$];
    string tag_q[$];

    int m_cwp, m_cs, m_cr, m_cl, m_ow;
    logic [5:0] m_ws;

    always #4 clk = ~clk;

    rwin_ctrl #(.NWIN(N), .DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .opa(opa), .opb(opb),
        .ld_en(ld_en), .ld_cwp(ld_cwp), .ld_cansave(ld_cs), .ld_canrestore(ld_cr),
        .ld_cleanwin(ld_cl), .ld_otherwin(ld_ow), .ld_wstate(ld_ws),
        .rsp_valid(rsp_valid), .rsp_commit(rsp_commit), .rsp_trap(rsp_trap),
        .rsp_kind(rsp_kind), .rsp_vec(rsp_vec), .rsp_redirect(rsp_redirect),
        .rsp_value(rsp_value), .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
        .cleanwin(cleanwin), .otherwin(otherwin), .wstate(wstate)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each response against the oldest expected item
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && rsp_valid) begin
                item_t act, e;
                act = '{rsp_commit, rsp_trap, rsp_kind, rsp_vec, rsp_redirect,
                        cwp, cansave, canrestore, rsp_value};
                if (exp_q.size() == 0) begin
                    compared++;
                    mismatched++;
                    $display("FAIL R11/R12 unexpected response actual=%h expected=none", act);
                end else begin
                    e = exp_q.pop_front();
                    check(tag_q.pop_front(), 128'(act), 128'(e));
                end
            end
        end
    end

    // driver: models the requirements and pushes the expected response
    task automatic do_req(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                          input string tag);
        item_t e;
        logic [2:0] fld;
        logic [W-1:0] t;
        t   = a + b;
        fld = (m_ow != 0) ? m_ws[5:3] : m_ws[2:0];
        e = '0;
        e.value = t;
        if (op == 1) begin
            if (m_cs == 0) begin e.kind = (m_ow != 0) ? 3'd2 : 3'd1; e.vec = fld; end
            else if (m_cl == m_cr) e.kind = 3'd5;
        end else begin
            if (m_cr == 0) begin e.kind = (m_ow != 0) ? 3'd4 : 3'd3; e.vec = fld; end
            else if (op == 3 && t[1:0] != 2'b00) e.kind = 3'd6;
        end
        e.trap   = (e.kind != 3'd0);
        e.commit = !e.trap;
        if (e.commit) begin
            if (op == 1) begin m_cwp = (m_cwp + 1) % N; m_cs--; m_cr++; end
            else begin m_cwp = (m_cwp + N - 1) % N; m_cs++; m_cr--; end
            e.redirect = (op == 3);
        end
        e.cwp = 5'(m_cwp); e.cs = 5'(m_cs); e.cr = 5'(m_cr);
        @(negedge clk);
        req_op = 2'(op); opa = a; opb = b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_op = 2'd0;
    endtask

    task automatic drive_load(input int c, input int s, input int r, input int l,
                              input int o, input logic [5:0] w);
        ld_en = 1'b1;
        ld_cwp = 5'(c); ld_cs = 5'(s); ld_cr = 5'(r); ld_cl = 5'(l); ld_ow = 5'(o); ld_ws = w;
        m_cwp = c; m_cs = s; m_cr = r; m_cl = l; m_ow = o; m_ws = w;
    endtask

    task automatic check_ctx(input string tag);
        check(tag, 128'({cwp, cansave, canrestore, cleanwin, otherwin, wstate}),
              128'({5'(m_cwp), 5'(m_cs), 5'(m_cr), 5'(m_cl), 5'(m_ow), m_ws}));
    endtask

    task automatic do_load(input int c, input int s, input int r, input int l,
                           input int o, input logic [5:0] w);
        @(negedge clk);
        drive_load(c, s, r, l, o, w);
        @(negedge clk);
        ld_en = 1'b0;
        check_ctx("R11 load");
    endtask

    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        m_cwp = 0; m_cs = N - 2; m_cr = 0; m_cl = N - 2; m_ow = 0; m_ws = 6'd0;
        check_ctx("R1 reset ctx");
        check("R1 reset valid", 128'(rsp_valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 idle no response", 128'(rsp_valid), 128'(0));

        do_load(0, N - 2, 0, N - 2, 0, 6'b101_011);
        do_req(2, 64'd7, 64'd9, "R5 fill normal");
        do_req(1, 64'd10, 64'd5, "R4 save commit");
        for (int i = 0; i < 5; i++) do_req(1, 64'(i), 64'd100, "R4 save chain");
        do_req(1, 64'd1, 64'd1, "R2 spill normal");
        do_load(6, 0, 6, 6, 2, 6'b101_011);
        do_req(1, 64'd3, 64'd4, "R2 spill other");
        do_load(7, 3, 2, 2, 0, 6'b101_011);
        do_req(1, 64'd0, 64'd0, "R3 clean window");
        do_load(7, 3, 2, 5, 0, 6'b101_011);
        do_req(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, "R4 save wrap R9");
        do_req(2, 64'd20, 64'd22, "R6 restore wrap");
        do_req(3, 64'h100, 64'd2, "R7 misaligned");
        do_req(3, 64'h100, 64'd1, "R7 misaligned bit0");
        do_load(3, 4, 0, 5, 1, 6'b101_011);
        do_req(3, 64'h100, 64'd3, "R7 fill before misalign");
        do_req(2, 64'd1, 64'd1, "R5 fill other");
        do_load(3, 4, 2, 5, 0, 6'b101_011);
        do_req(3, 64'h1000, 64'h20, "R8 return commit");
        do_req(2, 64'd4, 64'd4, "R8 restore no redirect");

        // R11: load wins over a simultaneous request
        @(negedge clk);
        drive_load(4, 2, 4, 7, 0, 6'b010_110);
        req_op = 2'd1; opa = 64'd5; opb = 64'd5;
        @(negedge clk);
        ld_en = 1'b0; req_op = 2'd0;
        check("R11 dropped request", 128'(rsp_valid), 128'(0));
        check_ctx("R11 load with request");

        do_load(2, 3, 3, 7, 0, 6'b110_001);
        for (int i = 0; i < 60; i++) begin
            int op;
            op = 1 + ((i * 7 + i / 5) % 3);
            if (i == 30) do_load(m_cwp, m_cs, m_cr, m_cl, 1, 6'b110_001);
            do_req(op, 64'(i * 37 + 5), 64'(i * 3), "R9 mixed sequence");
        end

        repeat (4) @(negedge clk);
        check("R12 queue drained", 128'(exp_q.size()), 128'(0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule